// File: doc/BRIEF.md
# Bit-Manipulation Coprocessor

This unit runs the basic bit-manipulation operations of a 32-bit integer core as a small multi-cycle coprocessor. The host pulses `start` for one cycle together with an operation code, the two source operands and an immediate rotate amount. The unit captures them, works on them for a fixed or operand-dependent number of cycles, and then raises `done` for one cycle with the 32-bit answer on `result`. The answer stays on `result` until the next operation completes.

The operations fall into two groups. The bitwise, compare and byte/extend operations always take the same short time. The rotates and the bit counts (leading zeros, trailing zeros, population count) form the shift class. With `FAST_SHIFT = 0` they go through one iterative engine that handles one bit position per cycle, so their latency follows the amount of work. With `FAST_SHIFT = 1` they use parallel rotators and counters with a fixed latency. Decoding, register access and trapping stay in the host.

In the requirements, the cycle in which `start` is sampled high counts as cycle 1. An operation with latency L has `done` high in cycle L.

Top module: `bmu_core`

## Requirements
- R1: Operation codes: 0 andn, 1 orn, 2 xnor, 3 max, 4 maxu, 5 min, 6 minu, 7 sext.b, 8 sext.h, 9 zext.h, 10 orc.b, 11 rev8, 12 clz, 13 ctz, 14 cpop, 15 rol, 16 ror, 17 rori. The bitwise operations return rs1 & ~rs2, rs1 | ~rs2 and ~(rs1 ^ rs2), with latency 3.
- R2: max and min compare as signed two's complement values. maxu and minu compare as unsigned values. All four have latency 3.
- R3: sext.b and sext.h sign-extend the low byte and the low halfword of rs1. zext.h zero-extends the low halfword. orc.b turns each byte of rs1 into 0xFF if any of its bits is set and into 0x00 otherwise. rev8 reverses the byte order. All five have latency 3.
- R4: clz and ctz count the zero bits above the highest set bit and below the lowest set bit of rs1. cpop counts the set bits. An all-zero rs1 gives 32 for clz and for ctz.
- R5: rol and ror rotate rs1 left or right by rs2[4:0]. rori rotates right by the 5-bit immediate. The upper bits of rs2 have no effect, and a rotate by 0 returns rs1.
- R6: With FAST_SHIFT = 0, a rotate has latency 4 plus its rotate amount, and clz, ctz and cpop have latency 36.
- R7: With FAST_SHIFT = 1, every shift-class operation has latency 4.
- R8: Each operation raises done for exactly one cycle. result changes only in a cycle where done is high, and it then holds until the next completion.
- R9: A start pulse while an operation is in flight is ignored. It produces no extra done and does not alter the running result.
- R10: After reset, done is low and result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; sampled only when idle |
| op | input | 5 | Operation code (see R1) |
| rs1 | input | 32 | First operand |
| rs2 | input | 32 | Second operand; low 5 bits are the rotate amount for rol/ror |
| imm_shamt | input | 5 | Immediate rotate amount for rori |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Result, held until the next completion |

## Verification
A wrong step counter in the iterative engine shows up at once as a completion strobe in the wrong cycle, and the bench sees it in the first rotate or count. A scan that does not stop after the first set bit shows up as a clz or ctz value that is too large. A control state that does not return to idle shows up as a missing or repeated done pulse within the same window. A state that accepts a request while busy shows up as a second done inside the observation window, or as a result taken from the intruding operands. Both the serial and the parallel variants run side by side on the same stimulus, so a latency or value mismatch in either one is reported in the operation that exposes it.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int XLEN = 32;
  localparam int CNTW = $clog2(XLEN) + 1;

  typedef enum logic [4:0] {
    OP_ANDN = 5'd0,  OP_ORN  = 5'd1,  OP_XNOR = 5'd2,
    OP_MAX  = 5'd3,  OP_MAXU = 5'd4,  OP_MIN  = 5'd5,  OP_MINU = 5'd6,
    OP_SEXB = 5'd7,  OP_SEXH = 5'd8,  OP_ZEXH = 5'd9,
    OP_ORCB = 5'd10, OP_REV8 = 5'd11,
    OP_CLZ  = 5'd12, OP_CTZ  = 5'd13, OP_CPOP = 5'd14,
    OP_ROL  = 5'd15, OP_ROR  = 5'd16, OP_RORI = 5'd17
  } bmu_op_e;

  typedef enum logic [2:0] {
    K_ROL, K_ROR, K_CLZ, K_CTZ, K_CPOP
  } shf_kind_e;

  function automatic logic is_shift_op(input logic [4:0] op);
    return (op >= OP_CLZ) && (op <= OP_RORI);
  endfunction

  function automatic shf_kind_e kind_of(input logic [4:0] op);
    case (op)
      OP_CLZ:  return K_CLZ;
      OP_CTZ:  return K_CTZ;
      OP_CPOP: return K_CPOP;
      OP_ROL:  return K_ROL;
      default: return K_ROR;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] f_basic(input logic [4:0] op,
                                              input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    r = '0;
    case (op)
      OP_ANDN: r = a & ~b;
      OP_ORN:  r = a | ~b;
      OP_XNOR: r = ~(a ^ b);
      OP_MAX:  r = ($signed(a) > $signed(b)) ? a : b;
      OP_MAXU: r = (a > b) ? a : b;
      OP_MIN:  r = ($signed(a) < $signed(b)) ? a : b;
      OP_MINU: r = (a < b) ? a : b;
      OP_SEXB: r = {{(XLEN-8){a[7]}}, a[7:0]};
      OP_SEXH: r = {{(XLEN-16){a[15]}}, a[15:0]};
      OP_ZEXH: r = {{(XLEN-16){1'b0}}, a[15:0]};
      OP_ORCB: for (int k = 0; k < XLEN/8; k++) r[8*k +: 8] = {8{|a[8*k +: 8]}};
      OP_REV8: for (int k = 0; k < XLEN/8; k++) r[8*k +: 8] = a[8*(XLEN/8-1-k) +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [CNTW-1:0] f_lead0(input logic [XLEN-1:0] a);
    logic [CNTW-1:0] n;
    logic hit;
    n = '0; hit = 1'b0;
    for (int k = XLEN-1; k >= 0; k--) begin
      hit = hit | a[k];
      if (!hit) n = n + CNTW'(1);
    end
    return n;
  endfunction

  function automatic logic [CNTW-1:0] f_trail0(input logic [XLEN-1:0] a);
    logic [CNTW-1:0] n;
    logic hit;
    n = '0; hit = 1'b0;
    for (int k = 0; k < XLEN; k++) begin
      hit = hit | a[k];
      if (!hit) n = n + CNTW'(1);
    end
    return n;
  endfunction

  function automatic logic [CNTW-1:0] f_ones(input logic [XLEN-1:0] a);
    logic [CNTW-1:0] n;
    n = '0;
    for (int k = 0; k < XLEN; k++) n = n + CNTW'(a[k]);
    return n;
  endfunction

  function automatic logic [XLEN-1:0] f_rotl(input logic [XLEN-1:0] a,
                                             input logic [CNTW-1:0] s);
    return (a << s) | (a >> (CNTW'(XLEN) - s));
  endfunction

  function automatic logic [XLEN-1:0] f_rotr(input logic [XLEN-1:0] a,
                                             input logic [CNTW-1:0] s);
    return (a >> s) | (a << (CNTW'(XLEN) - s));
  endfunction
endpackage

// File: rtl/bmu_basic_unit.sv
module bmu_basic_unit
  import bmu_pkg::*;
(
  input  logic [4:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] value_o
);
  always_comb value_o = f_basic(op_i, a_i, b_i);
endmodule

// File: rtl/bmu_fast_unit.sv
module bmu_fast_unit
  import bmu_pkg::*;
(
  input  shf_kind_e       kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [CNTW-1:0] amount_i,
  output logic [XLEN-1:0] value_o
);
  always_comb begin
    case (kind_i)
      K_ROL:   value_o = f_rotl(a_i, amount_i);
      K_ROR:   value_o = f_rotr(a_i, amount_i);
      K_CLZ:   value_o = XLEN'(f_lead0(a_i));
      K_CTZ:   value_o = XLEN'(f_trail0(a_i));
      default: value_o = XLEN'(f_ones(a_i));
    endcase
  end
endmodule

// File: rtl/bmu_serial_engine.sv
module bmu_serial_engine
  import bmu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  shf_kind_e       kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [CNTW-1:0] amount_i,
  output logic            last_o,
  output logic [XLEN-1:0] value_o
);
  logic [XLEN-1:0] acc;
  logic [CNTW-1:0] steps_left;
  logic [CNTW-1:0] tally;
  logic            seen;
  logic            running;
  shf_kind_e       kind_q;

  assign last_o = running && (steps_left == '0);
  assign value_o = (kind_q == K_ROL || kind_q == K_ROR) ? acc : XLEN'(tally);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; steps_left <= '0; tally <= '0; seen <= 1'b0;
      running <= 1'b0; kind_q <= K_ROL;
    end else if (load_i) begin
      acc <= a_i; steps_left <= amount_i; tally <= '0; seen <= 1'b0;
      running <= 1'b1; kind_q <= kind_i;
    end else if (running) begin
      if (steps_left == '0) begin
        running <= 1'b0;
      end else begin
        steps_left <= steps_left - CNTW'(1);
        case (kind_q)
          K_ROL: acc <= {acc[XLEN-2:0], acc[XLEN-1]};
          K_ROR: acc <= {acc[0], acc[XLEN-1:1]};
          K_CLZ: begin
            acc <= acc << 1;
            if (acc[XLEN-1]) seen <= 1'b1;
            else if (!seen) tally <= tally + CNTW'(1);
          end
          K_CTZ: begin
            acc <= acc >> 1;
            if (acc[0]) seen <= 1'b1;
            else if (!seen) tally <= tally + CNTW'(1);
          end
          default: begin
            acc <= acc >> 1;
            tally <= tally + CNTW'(acc[0]);
          end
        endcase
      end
    end
  end

  // R6
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && steps_left != '0 && !load_i) |=> (steps_left == $past(steps_left) - CNTW'(1)));

  // R4
  tally_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tally <= CNTW'(XLEN));
endmodule

// File: rtl/bmu_core.sv
module bmu_core
  import bmu_pkg::*;
#(
  parameter bit FAST_SHIFT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [4:0]  op,
  input  logic [31:0] rs1,
  input  logic [31:0] rs2,
  input  logic [4:0]  imm_shamt,
  output logic        done,
  output logic [31:0] result
);
  typedef enum logic [1:0] {ST_IDLE, ST_BASIC, ST_SHIFT, ST_ITER} st_e;

  st_e             state;
  logic [4:0]      op_q;
  logic [XLEN-1:0] a_q, b_q;
  logic [CNTW-1:0] amt_q;
  shf_kind_e       kind_q;
  logic [XLEN-1:0] basic_val;
  logic [XLEN-1:0] sh_val;
  logic            sh_last;
  logic            accept;

  assign accept = start && (state == ST_IDLE);

  function automatic logic [CNTW-1:0] amount_of(input logic [4:0] o,
                                                input logic [XLEN-1:0] b,
                                                input logic [4:0] imm);
    case (o)
      OP_ROL, OP_ROR: return CNTW'(b[4:0]);
      OP_RORI:        return CNTW'(imm);
      default:        return CNTW'(XLEN);
    endcase
  endfunction

  bmu_basic_unit u_basic (.op_i(op_q), .a_i(a_q), .b_i(b_q), .value_o(basic_val));

  generate
    if (FAST_SHIFT) begin : g_fast
      logic [XLEN-1:0] fast_val, stage;
      bmu_fast_unit u_fast (.kind_i(kind_q), .a_i(a_q), .amount_i(amt_q), .value_o(fast_val));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else if (state == ST_SHIFT) stage <= fast_val;
      end
      assign sh_val  = stage;
      assign sh_last = (state == ST_ITER);

      // R7
      fast_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |=> ##1 done);
    end else begin : g_serial
      bmu_serial_engine u_eng (
        .clk(clk), .rst_n(rst_n), .load_i(state == ST_SHIFT),
        .kind_i(kind_q), .a_i(a_q), .amount_i(amt_q),
        .last_o(sh_last), .value_o(sh_val)
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; op_q <= '0; a_q <= '0; b_q <= '0;
      amt_q <= '0; kind_q <= K_ROL; done <= 1'b0; result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          op_q   <= op;
          a_q    <= rs1;
          b_q    <= rs2;
          amt_q  <= amount_of(op, rs2, imm_shamt);
          kind_q <= kind_of(op);
          state  <= is_shift_op(op) ? ST_SHIFT : ST_BASIC;
        end
        ST_BASIC: begin
          result <= basic_val;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        ST_SHIFT: state <= ST_ITER;
        default: if (sh_last) begin
          result <= sh_val;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  // R1
  basic_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BASIC) |=> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE) |=> (state != ST_BASIC && state != ST_SHIFT) || $stable(a_q));
endmodule

// File: tb/test_bmu_core.sv
module test_bmu_core;
  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] rs1 = '0, rs2 = '0;
  logic [4:0]  imm_shamt = '0;
  logic        done_s, done_f;
  logic [31:0] result_s, result_f;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmu_core #(.FAST_SHIFT(1'b0)) i_bmu_core (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rs1(rs1), .rs2(rs2),
    .imm_shamt(imm_shamt), .done(done_s), .result(result_s));

  bmu_core #(.FAST_SHIFT(1'b1)) i_bmu_core_fast (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rs1(rs1), .rs2(rs2),
    .imm_shamt(imm_shamt), .done(done_f), .result(result_f));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual hung expected finish");
      errors = errors + 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_res(input logic [4:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] imm);
    logic [63:0] dbl;
    int n;
    dbl = {a, a};
    case (o)
      0: return a & ~b;
      1: return ~(~a & b);
      2: return (a & b) | (~a & ~b);
      3: return (signed'(a) >= signed'(b)) ? a : b;
      4: return (a >= b) ? a : b;
      5: return (signed'(a) <= signed'(b)) ? a : b;
      6: return (a <= b) ? a : b;
      7: return 32'(signed'(a[7:0]));
      8: return 32'(signed'(a[15:0]));
      9: return {16'h0, a[15:0]};
      10: begin
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++)
          if ((a & (32'hFF << (8*k))) != 0) r = r | (32'hFF << (8*k));
        return r;
      end
      11: return {a[7:0], a[15:8], a[23:16], a[31:24]};
      12: begin n = 0; while (n < 32 && a[31-n] == 1'b0) n++; return n; end
      13: begin n = 0; while (n < 32 && a[n] == 1'b0) n++; return n; end
      14: begin n = 0; for (int k = 0; k < 32; k++) if (a[k]) n++; return n; end
      15: begin dbl = dbl << b[4:0]; return dbl[63:32]; end
      16: begin dbl = dbl >> b[4:0]; return dbl[31:0]; end
      17: begin dbl = dbl >> imm; return dbl[31:0]; end
      default: return 32'h0;
    endcase
  endfunction

  function automatic int m_lat(input logic [4:0] o, input logic [31:0] b,
                               input logic [4:0] imm, input bit fast);
    if (o < 12) return 3;
    if (fast) return 4;
    if (o == 15 || o == 16) return 4 + int'(b[4:0]);
    if (o == 17) return 4 + int'(imm);
    return 36;
  endfunction

  task automatic run_op(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] imm, input string tag, input bit poke);
    int first_s = -1, first_f = -1, n_s = 0, n_f = 0;
    logic [31:0] got_s = '0, got_f = '0, exp;
    string ltag_s, ltag_f;
    exp = m_res(o, a, b, imm);
    @(negedge clk);
    op = o; rs1 = a; rs2 = b; imm_shamt = imm; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 2; c <= WINDOW; c++) begin
      if (done_s) begin n_s++; if (first_s < 0) begin first_s = c; got_s = result_s; end end
      if (done_f) begin n_f++; if (first_f < 0) begin first_f = c; got_f = result_f; end end
      if (poke && c == 3) begin op = 5'd0; rs1 = ~a; rs2 = 32'h0; start = 1'b1; end
      else start = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    start = 1'b0;
    ltag_s = (o >= 12) ? "R6" : tag;
    ltag_f = (o >= 12) ? "R7" : tag;
    chk(got_s == exp, tag, "serial result", got_s, exp);
    chk(got_f == exp, tag, "fast result", got_f, exp);
    chk(first_s == m_lat(o, b, imm, 1'b0), ltag_s, "serial latency", first_s, m_lat(o, b, imm, 1'b0));
    chk(first_f == m_lat(o, b, imm, 1'b1), ltag_f, "fast latency", first_f, m_lat(o, b, imm, 1'b1));
    chk(n_s == 1 && n_f == 1, poke ? "R9" : "R8", "done pulse count", n_s * 16 + n_f, 32'h11);
    chk(result_s == exp && result_f == exp, poke ? "R9" : "R8", "held result",
        result_s ^ result_f, 32'h0);
  endtask

  task automatic t_reset();
    // R10
    chk(done_s == 1'b0 && done_f == 1'b0, "R10", "done after reset", {done_s, done_f}, 0);
    chk(result_s == 0 && result_f == 0, "R10", "result after reset", result_s | result_f, 0);
  endtask

  task automatic t_logic();
    // R1
    run_op(5'd0, 32'hF0F0_1234, 32'h0FF0_00FF, 5'd0, "R1", 1'b0);
    run_op(5'd1, 32'h0000_1000, 32'hFFFF_0F0F, 5'd0, "R1", 1'b0);
    run_op(5'd2, 32'hA5A5_5A5A, 32'h0F0F_F0F0, 5'd0, "R1", 1'b0);
  endtask

  task automatic t_compare();
    // R2
    run_op(5'd3, 32'hFFFF_FFFE, 32'h0000_0003, 5'd0, "R2", 1'b0);
    run_op(5'd4, 32'hFFFF_FFFE, 32'h0000_0003, 5'd0, "R2", 1'b0);
    run_op(5'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, "R2", 1'b0);
    run_op(5'd6, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, "R2", 1'b0);
  endtask

  task automatic t_misc();
    // R3
    run_op(5'd7, 32'h1234_5680, 32'h0, 5'd0, "R3", 1'b0);
    run_op(5'd8, 32'h0000_7FFF, 32'h0, 5'd0, "R3", 1'b0);
    run_op(5'd8, 32'h1234_8001, 32'h0, 5'd0, "R3", 1'b0);
    run_op(5'd9, 32'hDEAD_BEEF, 32'h0, 5'd0, "R3", 1'b0);
    run_op(5'd10, 32'h0100_8000, 32'h0, 5'd0, "R3", 1'b0);
    run_op(5'd11, 32'h1122_3344, 32'h0, 5'd0, "R3", 1'b0);
  endtask

  task automatic t_count();
    // R4
    run_op(5'd12, 32'h0001_0000, 32'h0, 5'd0, "R4", 1'b0);
    run_op(5'd12, 32'h0, 32'h0, 5'd0, "R4", 1'b0);
    run_op(5'd13, 32'h0000_0100, 32'h0, 5'd0, "R4", 1'b0);
    run_op(5'd13, 32'h0, 32'h0, 5'd0, "R4", 1'b0);
    run_op(5'd14, 32'hF00F_0001, 32'h0, 5'd0, "R4", 1'b0);
    run_op(5'd14, 32'hFFFF_FFFF, 32'h0, 5'd0, "R4", 1'b0);
  endtask

  task automatic t_rotate();
    // R5 (upper rs2 bits set to show they are ignored)
    run_op(5'd15, 32'h8000_0001, 32'hFFFF_FFE4, 5'd0, "R5", 1'b0);
    run_op(5'd16, 32'h8000_0001, 32'h0000_0101, 5'd0, "R5", 1'b0);
    run_op(5'd17, 32'h1234_5678, 32'h0000_001F, 5'd31, "R5", 1'b0);
    run_op(5'd15, 32'hCAFE_BABE, 32'hFFFF_FFE0, 5'd0, "R5", 1'b0);
    run_op(5'd17, 32'hCAFE_BABE, 32'h0, 5'd0, "R5", 1'b0);
  endtask

  task automatic t_busy();
    // R9
    run_op(5'd12, 32'h0000_00F0, 32'h0, 5'd0, "R9", 1'b1);
    run_op(5'd16, 32'h0000_0003, 32'h0000_0010, 5'd0, "R9", 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_logic();
    t_compare();
    t_misc();
    t_count();
    t_rotate();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule